// File: doc/BRIEF.md
# Soft-Start Reference Ramp

This block produces the digital reference code for a power-converter error amplifier during start-up. A DAC outside the block turns the code into the amplifier's reference voltage. After a start request the code climbs from zero to full scale in equal unit steps, so the regulated output rises smoothly instead of overshooting.

Time is measured in oscillator ticks, which arrive on a single-cycle strobe. The code goes up by one on every sixteenth tick. The final step is stretched so that the ramp ends exactly 2047 ticks after the start request. With a 7-bit code the ramp has 127 steps. Each step is about 9.7 mV at the DAC, giving about 1.23 V at full scale.

A start request comes from release of the undervoltage lockout or from a fault restart. Any such request begins a new ramp from zero, even if a ramp is already running or has finished. When the enable input goes low the code and the done flag are cleared, and the block waits for the next start request.

Top module: `ss_ref_ramp`

## Requirements
- R1: After reset `ref_code` is 0 and `done` is 0.
- R2: A `start` pulse while `en` is high sets `ref_code` to 0 and begins a ramp. The code stays at 0 until 16 ticks have been counted.
- R3: During a ramp, `ref_code` equals k once 16*k ticks have been counted since the start, for k from 1 to 126.
- R4: The final step, from 126 to 127, takes place on tick 2047 after the start. Ticks 2017 to 2046 leave the code at 126.
- R5: After the final step `ref_code` holds at 127 and `done` is 1. Further ticks change neither of them.
- R6: Only clock cycles with `tick` high are counted. While `tick` stays low, `ref_code` does not change.
- R7: A `start` pulse during a ramp, or after it has completed, sets `ref_code` to 0 and `done` to 0, and a new ramp begins.
- R8: With `en` low, `ref_code` and `done` are 0 from the next clock edge, and `start` is ignored. When `en` returns high, no ramp runs until a new `start` arrives.
- R9: `ref_code` only ever increases by exactly one or returns to 0.
- R10: When `start` and `tick` are high in the same cycle, that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low clears and halts the ramp |
| start | input | 1 | Start request (lockout release or fault restart), one cycle |
| tick | input | 1 | Oscillator tick strobe, one cycle |
| ref_code | output | 7 | Reference code to the DAC |
| done | output | 1 | High once the code has reached full scale |

## Verification
The embedded assertions are checked on every cycle. They cover four properties:
- The code only steps up by one or drops to zero.
- The code changes only on a counted tick.
- The code and `done` hold once the ramp is complete.
- The code and `done` clear after `en` goes low.

The exact tick counts cannot be stated as a short property. These are the 16-tick spacing, the padded final step at tick 2047, and the rule that a `start` coinciding with a tick does not count that tick. The bench's directed scenarios cover them, along with restart from the middle of a ramp and from the completed state, and the rule that no ramp resumes when `en` returns.

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp #(
  parameter int CODE_W     = 7,
  parameter int STEP_TICKS = 16,
  parameter int RAMP_TICKS = 2047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              tick,
  output logic [CODE_W-1:0] ref_code,
  output logic              done
);
  localparam int FULL  = (1 << CODE_W) - 1;
  localparam int CNT_W = $clog2(RAMP_TICKS + 1);

  logic              running;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] code;

  wire [CNT_W-1:0] cnt_nx   = cnt + 1'b1;
  wire             last_tk  = (cnt_nx == CNT_W'(RAMP_TICKS));
  wire             step_hit = ((cnt_nx % CNT_W'(STEP_TICKS)) == '0) && (code < CODE_W'(FULL - 1));
  wire             count_en = running && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      code    <= '0;
      done    <= 1'b0;
    end else if (!en) begin
      running <= 1'b0;
      cnt     <= '0;
      code    <= '0;
      done    <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      code    <= '0;
      done    <= 1'b0;
    end else if (count_en) begin
      cnt <= cnt_nx;
      if (step_hit || last_tk) code <= code + 1'b1;
      if (last_tk) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  assign ref_code = code;

  initial begin
    assert (RAMP_TICKS > STEP_TICKS * (FULL - 1))
      else $error("ramp length too short for step count");
  end

  // R9: monotonic by single steps, or cleared to zero
  p_unit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code != $past(ref_code)) |-> (ref_code == '0) || (ref_code == $past(ref_code) + 1'b1));

  // R6: a non-zero change needs a tick in the previous cycle
  p_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code != $past(ref_code)) && (ref_code != '0) |-> $past(tick) && $past(en));

  // R5: completed ramp holds until start or disable
  p_hold_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && en && !start |=> done && (ref_code == CODE_W'(FULL)));

  // R5: done only at full scale
  p_done_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ref_code == CODE_W'(FULL));

  // R8: disable clears outputs
  p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ref_code == '0) && !done);

  // R7: start clears outputs
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ref_code == '0) && !done);
endmodule

// File: tb/tb_ss_ref_ramp.sv
module tb_ss_ref_ramp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       start = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] ref_code;
  logic       done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  ss_ref_ramp dut (.clk(clk), .rst_n(rst_n), .en(en), .start(start), .tick(tick),
                   .ref_code(ref_code), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 code", ref_code, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_full_ramp();
    en = 1'b1;
    pulse_start();
    chk("R2 code after start", ref_code, 0);
    ticks(15);
    chk("R2 code at 15 ticks", ref_code, 0);
    ticks(1);
    chk("R3 code at 16 ticks", ref_code, 1);
    // R3 R9: each step one higher
    for (int k = 2; k <= 126; k++) begin
      ticks(16);
      chk("R3 step", ref_code, k);
    end
    ticks(30);
    chk("R4 code at 2046 ticks", ref_code, 126);
    chk("R4 done at 2046 ticks", done, 0);
    ticks(1);
    chk("R4 code at 2047 ticks", ref_code, 127);
    chk("R5 done", done, 1);
    ticks(20);
    chk("R5 code hold", ref_code, 127);
    chk("R5 done hold", done, 1);
  endtask

  task automatic t_restart_done();
    pulse_start();
    chk("R7 code after restart from done", ref_code, 0);
    chk("R7 done cleared", done, 0);
    ticks(16);
    chk("R7 new ramp first step", ref_code, 1);
  endtask

  task automatic t_idle_mid();
    ticks(24);
    chk("R6 code before idle", ref_code, 2);
    repeat (12) @(negedge clk);
    chk("R6 code after idle", ref_code, 2);
    ticks(8);
    chk("R6 code resumes", ref_code, 3);
  endtask

  task automatic t_restart_mid();
    pulse_start();
    chk("R7 code after mid restart", ref_code, 0);
    ticks(16);
    chk("R7 count restarted", ref_code, 1);
  endtask

  task automatic t_enable();
    ticks(20);
    chk("R8 code before disable", ref_code, 2);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R8 code cleared", ref_code, 0);
    chk("R8 done cleared", done, 0);
    pulse_start();
    ticks(32);
    chk("R8 start ignored when disabled", ref_code, 0);
    @(negedge clk) en = 1'b1;
    ticks(32);
    chk("R8 no resume without start", ref_code, 0);
    pulse_start();
    ticks(16);
    chk("R8 ramp after new start", ref_code, 1);
  endtask

  task automatic t_coincide();
    @(negedge clk) begin start = 1'b1; tick = 1'b1; end
    @(negedge clk) begin start = 1'b0; tick = 1'b0; end
    ticks(15);
    chk("R10 coincident tick not counted", ref_code, 0);
    ticks(1);
    chk("R10 step after 16 further ticks", ref_code, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_ramp();
    t_restart_done();
    t_idle_mid();
    t_restart_mid();
    t_enable();
    t_coincide();
    finish_run();
  end
endmodule